// File: doc/BRIEF.md
# Fixed-Point DSP Multiply-Accumulate Unit

This block is a pipelined arithmetic unit that works beside a general-purpose ALU. It takes its two 32-bit operands straight from the shared register file, so no data has to be copied between the ALU and this unit. A caller presents an opcode and two operands with an issue strobe. Three cycles later the unit raises result-valid together with a 32-bit result. The caller can issue a new operation every cycle. The ALU and load/store logic are never held up while an operation is in flight.

The unit has two operand formats. The 16-bit format treats each 32-bit word as two signed halves. The real half (or high half) sits in bits 31:16 and the imaginary half (or low half) in bits 15:0. In this format the unit offers multiply, multiply-accumulate into a 32-bit accumulator, complex multiply, complex multiply-accumulate into a 64-bit accumulator split in two lanes, a paired add/subtract and a per-half arithmetic shift. The 32-bit format offers a full signed multiply, and a multiply-add or multiply-subtract on the 64-bit accumulator. Both accumulators are visible at the ports. Each is read and written in the last pipeline stage, so a chain of accumulating operations issued back to back needs no bubble.

Top module: `dsp_mac_unit`

## Requirements
- R1: `res_vld_o` is high in exactly the third cycle after each cycle with `issue_i` high, and never otherwise. A new operation is accepted every cycle.
- R2: Opcode 0 (half multiply) returns the full signed 32-bit product of the low halves of A and B.
- R3: Opcode 1 (half MAC) adds the signed low-half product into `acc32_o`, wrapping modulo 2^32, and returns the new accumulator value. Back-to-back MACs each see the result of the previous one.
- R4: Opcode 2 (complex multiply) returns Re = (ar*br − ai*bi) in bits 31:16 and Im = (ar*bi + ai*br) in bits 15:0. Each lane is arithmetic-shifted right by 15 and truncated to 16 bits.
- R5: Opcode 3 (complex MAC) returns the same word as opcode 2. It also adds the sign-extended Re into `acc64_o[63:32]` and the sign-extended Im into `acc64_o[31:0]`, each lane wrapping modulo 2^32 with no carry between lanes.
- R6: Opcode 4 (add/subtract) returns (A[31:16] + B[31:16]) in bits 31:16 and (A[15:0] − B[15:0]) in bits 15:0, each wrapping in 16 bits.
- R7: Opcode 5 (half shift) shifts each 16-bit half of A by the two's-complement amount in B[4:0]. A positive amount shifts left and drops the bits shifted out. A negative amount shifts arithmetically right, so −16 gives pure sign fill.
- R8: Opcode 6 (word multiply) loads the full signed 64-bit product A*B into `acc64_o` and returns its low 32 bits.
- R9: Opcode 7 adds and opcode 8 subtracts the signed 64-bit product A*B to/from `acc64_o`, wrapping modulo 2^64. Each returns the low 32 bits of the new accumulator.
- R10: After reset, both accumulators, the result and `res_vld_o` are zero. An accumulator changes only when an operation that targets it completes.
- R11: Opcodes 9 to 15 complete with a zero result and leave both accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Accept the opcode and operands this cycle |
| opcode_i | input | 4 | Operation select (0 to 8 defined) |
| src_a_i | input | 32 | Operand A from the register file |
| src_b_i | input | 32 | Operand B from the register file |
| res_vld_o | output | 1 | Result valid, three cycles after issue |
| result_o | output | 32 | Result word, held until the next completion |
| acc32_o | output | 32 | 32-bit accumulator |
| acc64_o | output | 64 | 64-bit accumulator |

## Verification
Every result is due in the third cycle after its issue cycle. The accumulators take their new values at the same clock edge that raises `res_vld_o`. The bench records the cycle number of each issue along with the result it expects. A monitor then samples on the falling edge and requires each valid to arrive exactly three cycles after its matching issue, in issue order. Accumulator values are compared only after the pipeline has drained, that is at least three idle cycles after the last issue. This lets back-to-back accumulate chains be checked against the final value a sequential model produces.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  localparam int DW  = 32;
  localparam int HW  = DW / 2;
  localparam int OPW = 4;
  localparam int NPROD = 4;

  // half-product lane indices: x-half * y-half
  localparam int PR_RR = 0;  // A hi * B hi
  localparam int PR_II = 1;  // A lo * B lo
  localparam int PR_RI = 2;  // A hi * B lo
  localparam int PR_IR = 3;  // A lo * B hi

  typedef enum logic [OPW-1:0] {
    OP_MUL16   = 4'd0,
    OP_MAC16   = 4'd1,
    OP_CMUL    = 4'd2,
    OP_CMAC    = 4'd3,
    OP_ADDSUB  = 4'd4,
    OP_SHIFT16 = 4'd5,
    OP_MUL32   = 4'd6,
    OP_MAC32   = 4'd7,
    OP_MSUB32  = 4'd8
  } dsp_op_e;

  function automatic logic [DW-1:0] mul_half(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic signed [DW-1:0] xs;
    logic signed [DW-1:0] ys;
    xs = {{HW{x[HW-1]}}, x};
    ys = {{HW{y[HW-1]}}, y};
    return xs * ys;
  endfunction

  function automatic logic [2*DW-1:0] mul_word(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic signed [2*DW-1:0] xs;
    logic signed [2*DW-1:0] ys;
    xs = {{DW{x[DW-1]}}, x};
    ys = {{DW{y[DW-1]}}, y};
    return xs * ys;
  endfunction

  // Q15 truncation of a 33-bit signed value: keep bits 30:15
  function automatic logic [HW-1:0] q15_cut(input logic [DW:0] v);
    return v[2*HW-2:HW-1];
  endfunction

  function automatic logic [HW-1:0] cplx_re(input logic [DW-1:0] prr, input logic [DW-1:0] pii);
    logic [DW:0] d;
    d = {prr[DW-1], prr} - {pii[DW-1], pii};
    return q15_cut(d);
  endfunction

  function automatic logic [HW-1:0] cplx_im(input logic [DW-1:0] pri, input logic [DW-1:0] pir);
    logic [DW:0] s;
    s = {pri[DW-1], pri} + {pir[DW-1], pir};
    return q15_cut(s);
  endfunction

  function automatic logic [DW-1:0] sext_half(input logic [HW-1:0] h);
    return {{HW{h[HW-1]}}, h};
  endfunction

  function automatic logic [DW-1:0] add_sub_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [HW-1:0] hi;
    logic [HW-1:0] lo;
    hi = a[DW-1:HW] + b[DW-1:HW];
    lo = a[HW-1:0] - b[HW-1:0];
    return {hi, lo};
  endfunction

  function automatic logic [HW-1:0] shift_half(input logic [HW-1:0] x, input logic [4:0] amt);
    logic signed [DW-1:0] xe;
    logic [4:0] neg;
    logic [DW-1:0] r;
    xe  = {{HW{x[HW-1]}}, x};
    neg = ~amt + 5'd1;
    if (!amt[4]) r = xe << amt;
    else         r = xe >>> neg;
    return r[HW-1:0];
  endfunction

  function automatic logic [DW-1:0] shift_pair(input logic [DW-1:0] a, input logic [4:0] amt);
    return {shift_half(a[DW-1:HW], amt), shift_half(a[HW-1:0], amt)};
  endfunction
endpackage

// File: rtl/dsp_mac_issue.sv
module dsp_mac_issue
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OP_W   = OPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              vld_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      op_o  <= '0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      vld_o <= issue_i;
      if (issue_i) begin
        op_o <= op_i;
        a_o  <= a_i;
        b_o  <= b_i;
      end
    end
  end
endmodule

// File: rtl/dsp_mac_mult.sv
module dsp_mac_mult
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OP_W   = OPW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vld_i,
  input  logic [OP_W-1:0]               op_i,
  input  logic [DATA_W-1:0]             a_i,
  input  logic [DATA_W-1:0]             b_i,
  output logic                          vld_o,
  output logic [OP_W-1:0]               op_o,
  output logic [NPROD-1:0][DATA_W-1:0]  prod_o,
  output logic [2*DATA_W-1:0]           wide_o,
  output logic [DATA_W-1:0]             lane_o
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar k = 0; k < NPROD; k++) begin : g_prod
    localparam bit X_HI = (k == PR_RR) || (k == PR_RI);
    localparam bit Y_HI = (k == PR_RR) || (k == PR_IR);
    logic [HALF_W-1:0] xh;
    logic [HALF_W-1:0] yh;
    assign xh = X_HI ? a_i[DATA_W-1:HALF_W] : a_i[HALF_W-1:0];
    assign yh = Y_HI ? b_i[DATA_W-1:HALF_W] : b_i[HALF_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prod_o[k] <= '0;
      else if (vld_i) prod_o[k] <= mul_half(xh, yh);
    end
  end

  logic [DATA_W-1:0] lane_n;
  always_comb begin
    if (op_i == OP_SHIFT16) lane_n = shift_pair(a_i, b_i[4:0]);
    else                    lane_n = add_sub_pair(a_i, b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      op_o   <= '0;
      wide_o <= '0;
      lane_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        op_o   <= op_i;
        wide_o <= mul_word(a_i, b_i);
        lane_o <= lane_n;
      end
    end
  end
endmodule

// File: rtl/dsp_mac_accum.sv
module dsp_mac_accum
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OP_W   = OPW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          vld_i,
  input  logic [OP_W-1:0]               op_i,
  input  logic [NPROD-1:0][DATA_W-1:0]  prod_i,
  input  logic [2*DATA_W-1:0]           wide_i,
  input  logic [DATA_W-1:0]             lane_i,
  output logic                          vld_o,
  output logic [DATA_W-1:0]             res_o,
  output logic [DATA_W-1:0]             acc32_o,
  output logic [2*DATA_W-1:0]           acc64_o,
  output logic                          acc32_we_o,
  output logic                          acc64_we_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;

  logic [HALF_W-1:0] re_h;
  logic [HALF_W-1:0] im_h;
  logic [DATA_W-1:0] res_n;
  logic [DATA_W-1:0] acc32_n;
  logic [ACC_W-1:0]  acc64_n;
  logic              sel32;
  logic              sel64;

  assign re_h = cplx_re(prod_i[PR_RR], prod_i[PR_II]);
  assign im_h = cplx_im(prod_i[PR_RI], prod_i[PR_IR]);

  always_comb begin
    res_n   = '0;
    acc32_n = acc32_o;
    acc64_n = acc64_o;
    sel32   = 1'b0;
    sel64   = 1'b0;
    case (op_i)
      OP_MUL16: res_n = prod_i[PR_II];
      OP_MAC16: begin
        acc32_n = acc32_o + prod_i[PR_II];
        res_n   = acc32_n;
        sel32   = 1'b1;
      end
      OP_CMUL: res_n = {re_h, im_h};
      OP_CMAC: begin
        acc64_n = {acc64_o[ACC_W-1:DATA_W] + sext_half(re_h),
                   acc64_o[DATA_W-1:0]     + sext_half(im_h)};
        res_n   = {re_h, im_h};
        sel64   = 1'b1;
      end
      OP_ADDSUB, OP_SHIFT16: res_n = lane_i;
      OP_MUL32: begin
        acc64_n = wide_i;
        res_n   = wide_i[DATA_W-1:0];
        sel64   = 1'b1;
      end
      OP_MAC32: begin
        acc64_n = acc64_o + wide_i;
        res_n   = acc64_n[DATA_W-1:0];
        sel64   = 1'b1;
      end
      OP_MSUB32: begin
        acc64_n = acc64_o - wide_i;
        res_n   = acc64_n[DATA_W-1:0];
        sel64   = 1'b1;
      end
      default: res_n = '0;
    endcase
  end

  assign acc32_we_o = vld_i & sel32;
  assign acc64_we_o = vld_i & sel64;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      acc32_o <= '0;
      acc64_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i)      res_o   <= res_n;
      if (acc32_we_o) acc32_o <= acc32_n;
      if (acc64_we_o) acc64_o <= acc64_n;
    end
  end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int OP_W   = OPW,
  parameter int ACC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              res_vld_o,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] acc32_o,
  output logic [ACC_W-1:0]  acc64_o
);
  logic                         s1_valid;
  logic [OP_W-1:0]              s1_op;
  logic [DATA_W-1:0]            s1_a;
  logic [DATA_W-1:0]            s1_b;
  logic                         s2_valid;
  logic [OP_W-1:0]              s2_op;
  logic [NPROD-1:0][DATA_W-1:0] s2_prod;
  logic [ACC_W-1:0]             s2_wide;
  logic [DATA_W-1:0]            s2_lane;
  logic                         acc32_we;
  logic                         acc64_we;

  dsp_mac_issue #(.DATA_W(DATA_W), .OP_W(OP_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(opcode_i),
    .a_i(src_a_i), .b_i(src_b_i),
    .vld_o(s1_valid), .op_o(s1_op), .a_o(s1_a), .b_o(s1_b)
  );

  dsp_mac_mult #(.DATA_W(DATA_W), .OP_W(OP_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .vld_i(s1_valid), .op_i(s1_op),
    .a_i(s1_a), .b_i(s1_b),
    .vld_o(s2_valid), .op_o(s2_op), .prod_o(s2_prod),
    .wide_o(s2_wide), .lane_o(s2_lane)
  );

  dsp_mac_accum #(.DATA_W(DATA_W), .OP_W(OP_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .vld_i(s2_valid), .op_i(s2_op),
    .prod_i(s2_prod), .wide_i(s2_wide), .lane_i(s2_lane),
    .vld_o(res_vld_o), .res_o(result_o),
    .acc32_o(acc32_o), .acc64_o(acc64_o),
    .acc32_we_o(acc32_we), .acc64_we_o(acc64_we)
  );
endmodule

// File: rtl/dsp_mac_checker.sv
module dsp_mac_checker #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_i,
  input logic              res_vld_o,
  input logic [DATA_W-1:0] acc32_o,
  input logic [ACC_W-1:0]  acc64_o,
  input logic              s2_valid,
  input logic              acc32_we,
  input logic              acc64_we
);
  logic [2:0] issue_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issue_hist <= '0;
    else        issue_hist <= {issue_hist[1:0], issue_i};
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o == issue_hist[2]);

  p_valid_from_s2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(s2_valid));

  p_acc32_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc32_we |=> $stable(acc32_o));

  p_acc64_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc64_we |=> $stable(acc64_o));

  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc32_we, acc64_we}));

  p_acc64_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc64_we |=> res_vld_o);
endmodule

bind dsp_mac_unit dsp_mac_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_dsp_mac_checker (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .res_vld_o(res_vld_o),
  .acc32_o(acc32_o), .acc64_o(acc64_o), .s2_valid(s2_valid),
  .acc32_we(acc32_we), .acc64_we(acc64_we)
);

// File: tb/test_dsp_mac_unit.sv
`timescale 1ns/1ps
module test_dsp_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        res_vld_o;
  logic [31:0] result_o;
  logic [31:0] acc32_o;
  logic [63:0] acc64_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_acc32 = '0;
  logic [63:0] m_acc64 = '0;

  int          q_cyc[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsp_mac_unit i_dsp_mac_unit (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_vld_o(res_vld_o),
    .result_o(result_o), .acc32_o(acc32_o), .acc64_o(acc64_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference arithmetic, written with plain integer types
  function automatic int sh(input logic [15:0] h);
    return int'(shortint'(h));
  endfunction

  function automatic logic [15:0] ref_shift(input logic [15:0] x, input logic [4:0] b);
    int amt;
    int v;
    amt = b[4] ? int'(b) - 32 : int'(b);
    v = sh(x);
    if (amt >= 0) v = v << amt;
    else          v = v >>> (-amt);
    return v[15:0];
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    longint re;
    longint im;
    longint p;
    logic [15:0] r16;
    logic [15:0] i16;
    re  = longint'(sh(a[31:16])) * sh(b[31:16]) - longint'(sh(a[15:0])) * sh(b[15:0]);
    im  = longint'(sh(a[31:16])) * sh(b[15:0]) + longint'(sh(a[15:0])) * sh(b[31:16]);
    r16 = 16'(re >>> 15);
    i16 = 16'(im >>> 15);
    p   = longint'(int'(a)) * longint'(int'(b));
    case (op)
      4'd0: return 32'(sh(a[15:0]) * sh(b[15:0]));
      4'd1: begin m_acc32 = m_acc32 + 32'(sh(a[15:0]) * sh(b[15:0])); return m_acc32; end
      4'd2: return {r16, i16};
      4'd3: begin
        m_acc64[63:32] = m_acc64[63:32] + 32'(int'(shortint'(r16)));
        m_acc64[31:0]  = m_acc64[31:0]  + 32'(int'(shortint'(i16)));
        return {r16, i16};
      end
      4'd4: return {a[31:16] + b[31:16], a[15:0] - b[15:0]};
      4'd5: return {ref_shift(a[31:16], b[4:0]), ref_shift(a[15:0], b[4:0])};
      4'd6: begin m_acc64 = 64'(p); return m_acc64[31:0]; end
      4'd7: begin m_acc64 = m_acc64 + 64'(p); return m_acc64[31:0]; end
      4'd8: begin m_acc64 = m_acc64 - 64'(p); return m_acc64[31:0]; end
      default: return 32'd0;
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    issue_i  = 1'b1;
    opcode_i = op;
    src_a_i  = a;
    src_b_i  = b;
    q_cyc.push_back(cyc);
    q_exp.push_back(model(op, a, b));
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    issue_i = 1'b0;
    repeat (4) @(negedge clk);
    check(q_exp.size() == 0, "R1 all results returned", 64'(q_exp.size()), 64'd0);
  endtask

  task automatic check_accs(input string tag);
    check(acc32_o == m_acc32, {tag, " acc32"}, 64'(acc32_o), 64'(m_acc32));
    check(acc64_o == m_acc64, {tag, " acc64"}, acc64_o, m_acc64);
  endtask

  // result monitor: order, latency and value of every completion
  always @(negedge clk) begin
    if (rst_n && res_vld_o) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R1 valid without issue", 64'd1, 64'd0);
      end else begin
        int ic;
        logic [31:0] ex;
        string tg;
        ic = q_cyc.pop_front();
        ex = q_exp.pop_front();
        tg = q_tag.pop_front();
        check(cyc == ic + 3, "R1 latency", 64'(cyc - ic), 64'd3);
        check(result_o == ex, tg, 64'(result_o), 64'(ex));
      end
    end
  end

  task automatic t_reset();
    check(res_vld_o == 1'b0, "R10 reset valid", 64'(res_vld_o), 64'd0);
    check(result_o == '0, "R10 reset result", 64'(result_o), 64'd0);
    check_accs("R10 reset");
  endtask

  task automatic t_latency_single();
    send(4'd0, 32'h0, 32'h0000_0003, "R2 zero product");
    @(negedge clk); issue_i = 1'b0;
    check(res_vld_o == 1'b0, "R1 not early (1)", 64'(res_vld_o), 64'd0);
    @(negedge clk);
    check(res_vld_o == 1'b0, "R1 not early (2)", 64'(res_vld_o), 64'd0);
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R1 single result", 64'(q_exp.size()), 64'd0);
  endtask

  task automatic t_mul16();
    send(4'd0, 32'hABCD_0007, 32'h1234_0009, "R2 small");
    send(4'd0, 32'h0000_FFFF, 32'h0000_0002, "R2 neg x pos");
    send(4'd0, 32'h0000_8000, 32'h0000_8000, "R2 min x min");
    send(4'd0, 32'h0000_7FFF, 32'h0000_8000, "R2 max x min");
    drain();
  endtask

  task automatic t_mac16();
    send(4'd1, 32'h0000_0100, 32'h0000_0010, "R3 mac chain 1");
    send(4'd1, 32'h0000_FFFE, 32'h0000_0005, "R3 mac chain 2");
    send(4'd1, 32'h0000_8000, 32'h0000_8000, "R3 mac chain 3");
    send(4'd1, 32'h0000_8000, 32'h0000_8000, "R3 mac wrap");
    drain();
    check_accs("R3 after chain");
  endtask

  task automatic t_cmul();
    send(4'd2, 32'h4000_2000, 32'h4000_E000, "R4 cmul mixed");
    send(4'd2, 32'h8000_8000, 32'h8000_8000, "R4 cmul min");
    send(4'd2, 32'h7FFF_0001, 32'h8001_FFFF, "R4 cmul edge");
    drain();
    check_accs("R10 cmul no acc change");
  endtask

  task automatic t_cmac();
    send(4'd3, 32'h7FFF_7FFF, 32'h7FFF_7FFF, "R5 cmac 1");
    send(4'd3, 32'h8000_1234, 32'h7FFF_8000, "R5 cmac 2");
    send(4'd3, 32'h8000_8000, 32'h8000_8000, "R5 cmac 3");
    drain();
    check_accs("R5 lanes");
  endtask

  task automatic t_addsub();
    send(4'd4, 32'h7FFF_8000, 32'h0001_0001, "R6 wrap both");
    send(4'd4, 32'h1234_0010, 32'h1111_0020, "R6 plain");
    drain();
  endtask

  task automatic t_shift();
    send(4'd5, 32'h1234_F00F, 32'h0000_0000, "R7 shift 0");
    send(4'd5, 32'h1234_F00F, 32'h0000_0003, "R7 left 3");
    send(4'd5, 32'h0003_8001, 32'h0000_000F, "R7 left 15");
    send(4'd5, 32'h8000_7FFE, 32'h0000_001F, "R7 right 1");
    send(4'd5, 32'h8000_7FFF, 32'h0000_0010, "R7 right 16");
    send(4'd5, 32'hC000_4000, 32'hFFFF_FFE0, "R7 upper bits of B ignored");
    drain();
  endtask

  task automatic t_word();
    send(4'd6, 32'h8000_0000, 32'h8000_0000, "R8 min x min");
    send(4'd7, 32'hFFFF_FFFF, 32'h0000_0005, "R9 mac neg");
    send(4'd8, 32'h1234_5678, 32'h9ABC_DEF0, "R9 msub");
    send(4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9 mac big");
    drain();
    check_accs("R9 after chain");
    send(4'd6, 32'h0001_0000, 32'hFFFF_0000, "R8 reload");
    drain();
    check_accs("R8 reload");
  endtask

  task automatic t_unused();
    send(4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 op9 zero");
    send(4'd15, 32'h1234_5678, 32'h1234_5678, "R11 op15 zero");
    drain();
    check_accs("R11 accs kept");
  endtask

  task automatic t_mixed();
    send(4'd1, 32'h0000_0123, 32'h0000_0456, "R1 mixed mac16");
    send(4'd3, 32'h1000_2000, 32'h3000_4000, "R1 mixed cmac");
    send(4'd7, 32'h0000_1000, 32'h0000_1000, "R1 mixed mac32");
    send(4'd1, 32'h0000_FF00, 32'h0000_0100, "R1 mixed mac16 b");
    send(4'd4, 32'h0001_0001, 32'h0001_0001, "R1 mixed addsub");
    send(4'd8, 32'h0000_0002, 32'h0000_0003, "R1 mixed msub");
    drain();
    check_accs("R3 R9 mixed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency_single();
    t_mul16();
    t_mac16();
    t_cmul();
    t_cmac();
    t_addsub();
    t_shift();
    t_word();
    t_unused();
    t_mixed();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule